// File: doc/BRIEF.md
# Three-Digit Decimal to DAC Word Encoder

This block takes a three-digit decimal number, presented as three BCD digits from 000 to 999, and turns it into binary. It produces a 10-bit binary value and two 8-bit words for a pair of converters whose analogue outputs are later weighted and summed. The coarse word carries the upper two digits as a binary number from 0 to 99, shifted left by one place. The fine word carries the least-significant digit, shifted left by four places. Every multiply-by-ten is built from two shifted copies of its operand, added together.

The digits may change at any time. The outputs move only when a load strobe is sampled high, so an operator can enter a new number without disturbing the converters. If any digit holds a code above 9 when the strobe arrives, the load is refused, an error flag is raised, and the held words stay as they were. A valid flag shows that at least one good load has taken place.

Top module: `bcd3_dac_encoder`

## Requirements
- R1: After reset, `binValue`, `coarseWord` and `fineWord` are zero, and `wordsValid` and `codeError` are low.
- R2: When `loadStb` is sampled high and all three digits are 9 or less, `binValue` equals 100·hi + 10·mid + lo from the next clock edge on.
- R3: On the same accepted load, `coarseWord` becomes (10·hi + mid) × 2, where the ten-times product is formed as (hi<<1)+(hi<<3).
- R4: On the same accepted load, `fineWord` becomes lo × 16, so bits [3:0] of `fineWord` are zero and bits [7:4] hold lo.
- R5: While `loadStb` is low, changes on the digit inputs leave all three output words unchanged.
- R6: A load in which any digit is above 9 sets `codeError` high on the next edge. That load leaves all three words and `wordsValid` unchanged.
- R7: `wordsValid` rises one clock after the first accepted load and stays high. An accepted load clears `codeError`.
- R8: At the extremes, input 999 gives 999, 198 and 144, and input 000 gives zero on all three words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| digitHi | input | 4 | Hundreds digit, BCD |
| digitMid | input | 4 | Tens digit, BCD |
| digitLo | input | 4 | Units digit, BCD |
| loadStb | input | 1 | Capture strobe, sampled on the clock edge |
| binValue | output | 10 | Held binary value, 0 to 999 |
| coarseWord | output | 8 | Held upper-two-digit word, (10·hi+mid)<<1 |
| fineWord | output | 8 | Held units word, lo<<4 |
| wordsValid | output | 1 | High once a good load has been captured |
| codeError | output | 1 | High after a refused load, until the next accepted load |

## Verification
The case that is hardest to reach is a refused load that follows a good one. The check must show that no word moves, that `wordsValid` stays high and that `codeError` rises. The bench first loads a known value. It then changes the digits with the strobe low, and after that strobes a code above 9 in each digit position in turn. Between these steps it reads back the held words, and a final good load shows that the error flag clears.

// File: rtl/bcd3_enc_pkg.sv
package bcd3_enc_pkg;
  localparam int DIG_W  = 4;
  localparam int BIN_W  = 10;
  localparam int DAC_W  = 8;
  localparam int N_DIG  = 3;
  localparam int MAX_DIGIT = 9;

  typedef struct packed {
    logic capture;
    logic reject;
  } encStrobes_t;
endpackage

// File: rtl/bcd3_enc_ctrl.sv
module bcd3_enc_ctrl
  import bcd3_enc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadStb,
  input  logic        digitsOk,
  output encStrobes_t strb,
  output logic        wordsValid,
  output logic        codeError
);
  always_comb begin
    strb.capture = loadStb & digitsOk;
    strb.reject  = loadStb & ~digitsOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordsValid <= 1'b0;
      codeError  <= 1'b0;
    end else begin
      if (strb.capture) begin
        wordsValid <= 1'b1;
        codeError  <= 1'b0;
      end else if (strb.reject) begin
        codeError  <= 1'b1;
      end
    end
  end

  // R7: valid only rises after a strobe with good digits
  p_valid_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wordsValid) |-> $past(loadStb) && $past(digitsOk));

  // R7: valid never falls once set
  p_valid_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    wordsValid |=> wordsValid);

  // R6: a refused load raises the error flag
  p_bad_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && !digitsOk) |=> codeError);

  // R6: a refused load does not touch the valid flag
  p_bad_keeps_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && !digitsOk) |=> $stable(wordsValid));
endmodule

// File: rtl/bcd3_enc_datapath.sv
module bcd3_enc_datapath
  import bcd3_enc_pkg::*;
#(
  parameter int DigW      = DIG_W,
  parameter int BinW      = BIN_W,
  parameter int DacW      = DAC_W,
  parameter int CoarseShl = 1,
  parameter int FineShl   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DigW-1:0]   digitHi,
  input  logic [DigW-1:0]   digitMid,
  input  logic [DigW-1:0]   digitLo,
  input  encStrobes_t       strb,
  output logic              digitsOk,
  output logic [BinW-1:0]   binValue,
  output logic [DacW-1:0]   coarseWord,
  output logic [DacW-1:0]   fineWord
);
  localparam int NDig = N_DIG;
  localparam logic [DigW-1:0] DigMax = DigW'(MAX_DIGIT);

  logic [NDig-1:0][DigW-1:0] digVec;
  logic [NDig-1:0]           digOk;

  assign digVec = {digitHi, digitMid, digitLo};

  for (genvar g = 0; g < NDig; g++) begin : g_digChk
    assign digOk[g] = (digVec[g] <= DigMax);
  end

  assign digitsOk = &digOk;

  function automatic logic [BinW-1:0] timesTen(input logic [BinW-1:0] x);
    return (x << 1) + (x << 3);
  endfunction

  logic [BinW-1:0] upperBin;
  logic [BinW-1:0] fullBin;
  logic [DacW-1:0] coarseNext;
  logic [DacW-1:0] fineNext;

  always_comb begin
    upperBin   = timesTen(BinW'(digitHi)) + BinW'(digitMid);
    fullBin    = timesTen(upperBin) + BinW'(digitLo);
    coarseNext = DacW'(upperBin << CoarseShl);
    fineNext   = DacW'(BinW'(digitLo) << FineShl);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      binValue   <= '0;
      coarseWord <= '0;
      fineWord   <= '0;
    end else if (strb.capture) begin
      binValue   <= fullBin;
      coarseWord <= coarseNext;
      fineWord   <= fineNext;
    end
  end

  // R5, R6: words only move on a capture strobe
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(binValue) && $stable(coarseWord) && $stable(fineWord));

  // R2: held value stays in decimal range
  p_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    binValue <= BinW'(999));

  // R3: coarse word agrees with the binary value's upper digits
  p_coarse_rel_r3: assert property (@(posedge clk) disable iff (!rstN)
    32'(coarseWord) == 32'((binValue / 10) << CoarseShl));

  // R4: fine word agrees with the binary value's units digit
  p_fine_rel_r4: assert property (@(posedge clk) disable iff (!rstN)
    32'(fineWord) == 32'((binValue % 10) << FineShl));
endmodule

// File: rtl/bcd3_dac_encoder.sv
module bcd3_dac_encoder
  import bcd3_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIG_W-1:0] digitHi,
  input  logic [DIG_W-1:0] digitMid,
  input  logic [DIG_W-1:0] digitLo,
  input  logic             loadStb,
  output logic [BIN_W-1:0] binValue,
  output logic [DAC_W-1:0] coarseWord,
  output logic [DAC_W-1:0] fineWord,
  output logic             wordsValid,
  output logic             codeError
);
  encStrobes_t strb;
  logic        digitsOk;

  bcd3_enc_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .loadStb    (loadStb),
    .digitsOk   (digitsOk),
    .strb       (strb),
    .wordsValid (wordsValid),
    .codeError  (codeError)
  );

  bcd3_enc_datapath i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .digitHi    (digitHi),
    .digitMid   (digitMid),
    .digitLo    (digitLo),
    .strb       (strb),
    .digitsOk   (digitsOk),
    .binValue   (binValue),
    .coarseWord (coarseWord),
    .fineWord   (fineWord)
  );
endmodule

// File: tb/test_bcd3_dac_encoder.sv
module test_bcd3_dac_encoder;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] digitHi = '0, digitMid = '0, digitLo = '0;
  logic       loadStb = 1'b0;
  logic [9:0] binValue;
  logic [7:0] coarseWord, fineWord;
  logic       wordsValid, codeError;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bcd3_dac_encoder i_bcd3_dac_encoder (
    .clk(clk), .rstN(rstN), .digitHi(digitHi), .digitMid(digitMid),
    .digitLo(digitLo), .loadStb(loadStb), .binValue(binValue),
    .coarseWord(coarseWord), .fineWord(fineWord),
    .wordsValid(wordsValid), .codeError(codeError)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doLoad(input int h, input int m, input int l);
    @(negedge clk);
    digitHi = 4'(h); digitMid = 4'(m); digitLo = 4'(l);
    loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  task automatic checkWords(input string req, input int b, input int c, input int f);
    check({req, " binValue"}, int'(binValue), b);
    check({req, " coarseWord"}, int'(coarseWord), c);
    check({req, " fineWord"}, int'(fineWord), f);
  endtask

  task automatic t_reset_r1;
    checkWords("R1", 0, 0, 0);
    check("R1 wordsValid", int'(wordsValid), 0);
    check("R1 codeError", int'(codeError), 0);
  endtask

  task automatic t_first_load_r7;
    @(negedge clk);
    digitHi = 4'd3; digitMid = 4'd4; digitLo = 4'd7;
    loadStb = 1'b1;
    check("R7 valid before edge", int'(wordsValid), 0);
    @(negedge clk);
    loadStb = 1'b0;
    check("R7 valid one clock after load", int'(wordsValid), 1);
    checkWords("R2", 347, 68, 112);
  endtask

  task automatic t_patterns_r2;
    int vals[5] = '{250, 10, 905, 561, 89};
    foreach (vals[i]) begin
      int h = vals[i] / 100;
      int m = (vals[i] / 10) % 10;
      int l = vals[i] % 10;
      doLoad(h, m, l);
      check("R2 binValue", int'(binValue), vals[i]);
      check("R3 coarseWord", int'(coarseWord), (10 * h + m) * 2);
      check("R4 fineWord", int'(fineWord), l * 16);
      check("R4 fine low bits zero", int'(fineWord[3:0]), 0);
    end
  endtask

  task automatic t_extremes_r8;
    doLoad(9, 9, 9);
    checkWords("R8 max", 999, 198, 144);
    doLoad(0, 0, 0);
    checkWords("R8 zero", 0, 0, 0);
  endtask

  task automatic t_no_strobe_r5;
    doLoad(1, 2, 3);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      digitHi = 4'(k + 4); digitMid = 4'(9 - k); digitLo = 4'(k);
    end
    @(negedge clk);
    checkWords("R5 hold", 123, 24, 48);
  endtask

  task automatic t_bad_code_r6;
    for (int pos = 0; pos < 3; pos++) begin
      doLoad(4, 5, 6);
      check("R7 error cleared by good load", int'(codeError), 0);
      @(negedge clk);
      digitHi = 4'd4; digitMid = 4'd5; digitLo = 4'd6;
      if (pos == 0) digitHi = 4'd10;
      if (pos == 1) digitMid = 4'd12;
      if (pos == 2) digitLo = 4'd15;
      loadStb = 1'b1;
      @(negedge clk);
      loadStb = 1'b0;
      check("R6 codeError", int'(codeError), 1);
      check("R6 valid kept", int'(wordsValid), 1);
      checkWords("R6 words kept", 456, 90, 96);
    end
    doLoad(0, 7, 2);
    check("R7 error cleared", int'(codeError), 0);
    checkWords("R2 after error", 72, 14, 32);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r1();
    rstN = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_first_load_r7();
    t_patterns_r2();
    t_extremes_r8();
    t_no_strobe_r5();
    t_bad_code_r6();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule